// File: doc/BRIEF.md
# Asynchronous Parallel Register Port (Peripheral Side)

This block is the target side of an asynchronous byte-wide parallel port driven by an external controller. The controller opens a cycle by pulling either an address strobe or a data strobe low, with a write-enable level that says whether it writes or reads. The block brings these three control inputs into its clock domain through synchronisers. It answers with a wait line that goes high only when the cycle is complete. It then waits for the strobe to return high, releases the bus, and drops wait again. This is a full four-phase handshake.

Address cycles load or return an internal 8-bit register pointer. Data cycles become transfers on an internal register bus aimed at the pointed register. The register bus is a valid/ready interface. The block raises `reg_valid_o` together with the write flag, address and write data, and holds all of them stable until the register side answers with `reg_ready_i`. Read data is taken from `reg_rdata_i` in that same cycle. The register side applies back-pressure simply by holding ready low. While it does, the wait line stays low, so the stall reaches the external controller.

The bidirectional bus appears as separate input, output and output-enable signals; the pad itself lies outside the block. On reads, the output data is enabled for a configurable number of settle cycles before wait rises.

Top module: `pport_target`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `wait_n_o` is 0, `bus_oe_o` is 0 and `reg_valid_o` is 0.
- R2: An address cycle with write-enable low (write) loads the pointer from `bus_d_i`. An address cycle with write-enable high (read) drives the current pointer on `bus_d_o` with `bus_oe_o` high.
- R3: A data write issues one register-bus transfer with `reg_write_o`=1, `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the bus byte. A data read issues one transfer with `reg_write_o`=0 and places the returned `reg_rdata_i` on `bus_d_o`.
- R4: While `reg_valid_o` is high and `reg_ready_i` is low, `reg_valid_o`, `reg_addr_o`, `reg_write_o` and `reg_wdata_o` hold their values. `wait_n_o` stays 0 for as long as ready is withheld.
- R5: On every read cycle, `bus_oe_o` rises exactly SETTLE_CYCLES clock cycles before `wait_n_o` rises.
- R6: While `bus_oe_o` is high, `bus_d_o` does not change.
- R7: After the strobe returns high, `bus_oe_o` falls while `wait_n_o` is still 1. `wait_n_o` returns to 0 one cycle later and never falls while `bus_oe_o` is high.
- R8: `wait_n_o` rises only while a synchronised strobe is low. Each cycle is serviced exactly once, and no new cycle starts until both strobes have been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| astb_n_i | input | 1 | Address strobe, active low, asynchronous |
| dstb_n_i | input | 1 | Data strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write enable, low = write, high = read |
| bus_d_i | input | 8 | Byte sampled from the shared bus |
| bus_d_o | output | 8 | Byte driven onto the shared bus |
| bus_oe_o | output | 1 | Enable for bus_d_o at the pad |
| wait_n_o | output | 1 | Completion line, high when the cycle is done |
| reg_valid_o | output | 1 | Register-bus request valid |
| reg_write_o | output | 1 | Register-bus request is a write |
| reg_addr_o | output | 8 | Register address (the pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_ready_i | input | 1 | Register side accepts the request |
| reg_rdata_i | input | 8 | Register read data, valid with ready |

## Verification
The bench aims at a register side that withholds ready for long stretches. A design that ignored back-pressure would raise wait early, or let the request change, and a stale or wrong byte would reach the bus. It times the gap from output enable to wait on every read, which exposes an off-by-one settle counter or a missing settle stage. It also checks that the bus is released before wait drops and that a held strobe is serviced once. Reversed release order, or re-triggering on a level, shows up as an early wait edge or a duplicate register transfer.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REGBUS  = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_DONE    = 3'd3,
    ST_RELEASE = 3'd4
  } pport_state_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RESET_VAL;
          else        stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RESET_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          astb_s,
  input  logic          dstb_s,
  input  logic          wr_s,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  output logic          wait_n_o,
  output logic          reg_valid_o,
  output logic          reg_write_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic          reg_ready_i,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'((SETTLE_CYCLES > 0) ? SETTLE_CYCLES - 1 : 0);
  localparam pport_state_e AFTER_DRIVE = (SETTLE_CYCLES > 0) ? ST_SETTLE : ST_DONE;

  pport_state_e  state_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] dout_q, wdata_q;
  logic          oe_q, valid_q, write_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      dout_q  <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!astb_s) begin
            if (!wr_s) begin
              ptr_q   <= AW'(bus_d_i);
              state_q <= ST_DONE;
            end else begin
              dout_q  <= DW'(ptr_q);
              oe_q    <= 1'b1;
              cnt_q   <= '0;
              state_q <= AFTER_DRIVE;
            end
          end else if (!dstb_s) begin
            valid_q <= 1'b1;
            write_q <= !wr_s;
            wdata_q <= bus_d_i;
            state_q <= ST_REGBUS;
          end
        end
        ST_REGBUS: begin
          if (reg_ready_i) begin
            valid_q <= 1'b0;
            if (write_q) begin
              state_q <= ST_DONE;
            end else begin
              dout_q  <= reg_rdata_i;
              oe_q    <= 1'b1;
              cnt_q   <= '0;
              state_q <= AFTER_DRIVE;
            end
          end
        end
        ST_SETTLE: begin
          if (cnt_q == CNT_LAST) state_q <= ST_DONE;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: begin
          if (astb_s && dstb_s) begin
            oe_q    <= 1'b0;
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign wait_n_o    = (state_q == ST_DONE) || (state_q == ST_RELEASE);
  assign bus_oe_o    = oe_q;
  assign bus_d_o     = dout_q;
  assign reg_valid_o = valid_q;
  assign reg_write_o = write_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid_o && !reg_ready_i) |=> (reg_valid_o && $stable(reg_addr_o)
      && $stable(reg_write_o) && $stable(reg_wdata_o)));
  // R4
  no_ack_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid_o && !reg_ready_i) |=> !wait_n_o);
  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |=> (!bus_oe_o || $stable(bus_d_o)));
  // R7
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_o) |-> wait_n_o);
  // R7
  wait_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_n_o) |-> !bus_oe_o);
  // R8
  wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_n_o) |-> (!astb_s || !dstb_s));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n_o && !reg_valid_o && $past(!wait_n_o)) |-> (!bus_oe_o || !astb_s || !dstb_s || $past(!astb_s || !dstb_s)));
endmodule

// File: rtl/pport_target.sv
module pport_target #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          astb_n_i,
  input  logic          dstb_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  output logic          wait_n_o,
  output logic          reg_valid_o,
  output logic          reg_write_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic          reg_ready_i,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int NCTL = 3;
  logic [NCTL-1:0] ctl_s;

  pport_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({astb_n_i, dstb_n_i, wr_n_i}),
    .sync_o  (ctl_s)
  );

  pport_ctrl #(.DW(DW), .AW(AW), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .astb_s      (ctl_s[2]),
    .dstb_s      (ctl_s[1]),
    .wr_s        (ctl_s[0]),
    .bus_d_i     (bus_d_i),
    .bus_d_o     (bus_d_o),
    .bus_oe_o    (bus_oe_o),
    .wait_n_o    (wait_n_o),
    .reg_valid_o (reg_valid_o),
    .reg_write_o (reg_write_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_ready_i (reg_ready_i),
    .reg_rdata_i (reg_rdata_i)
  );
endmodule

// File: tb/pport_target_tb.sv
`timescale 1ns/1ps
module pport_target_tb_top;
  localparam int SETTLE = 3;

  logic clk = 0, rst_n = 0;
  logic astb_n = 1, dstb_n = 1, wr_n = 1;
  logic [7:0] bus_in = 0;
  logic [7:0] bus_out, reg_addr, reg_wdata, reg_rdata = 0;
  logic bus_oe, wait_n, reg_valid, reg_write, reg_ready = 0;

  int errors = 0, checks = 0, cyc = 0, xfers = 0;
  bit stall = 0;
  logic [7:0] rmem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 0;

  always #10 clk = ~clk;

  pport_target #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .astb_n_i(astb_n), .dstb_n_i(dstb_n), .wr_n_i(wr_n),
    .bus_d_i(bus_in), .bus_d_o(bus_out), .bus_oe_o(bus_oe), .wait_n_o(wait_n),
    .reg_valid_o(reg_valid), .reg_write_o(reg_write), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_ready_i(reg_ready), .reg_rdata_i(reg_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_read(input bit is_addr);
    return is_addr ? exp_ptr : exp_mem[exp_ptr];
  endfunction

  // register-side responder with random ready delay
  int dly = 0;
  bit prev_valid = 0;
  always @(negedge clk) begin
    reg_ready = 0;
    if (reg_valid && !prev_valid) dly = $urandom_range(0, 4);
    if (reg_valid && !stall) begin
      if (dly == 0) begin
        reg_ready = 1;
        reg_rdata = rmem[reg_addr];
        if (reg_write) rmem[reg_addr] = reg_wdata;
        xfers++;
      end else dly--;
    end
    prev_valid = reg_valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic start_op(input bit is_addr, input bit is_wr, input logic [7:0] wd);
    @(negedge clk);
    wr_n = !is_wr;
    bus_in = is_wr ? wd : 8'hzz;
    if (!is_wr) bus_in = $urandom;
    @(negedge clk);
    if (is_addr) astb_n = 0; else dstb_n = 0;
  endtask

  task automatic finish_op(input bit is_addr, input bit is_wr, input logic [7:0] wd);
    int oe_at = -1, w_at = -1, n = 0, x0;
    logic [7:0] exp_rd;
    bit saw_rel = 0;
    exp_rd = expect_read(is_addr);
    x0 = xfers;
    while (!wait_n && n < 300) begin
      @(negedge clk); n++;
      if (bus_oe && oe_at < 0) oe_at = n;
    end
    w_at = n;
    if (!wait_n) chk(0, "R8 wait timeout", 0, 1);
    if (!is_wr) begin
      chk(bus_oe && bus_out == exp_rd, is_addr ? "R2 addr read" : "R3 data read", bus_out, exp_rd);
      // R5 settle gap
      chk(w_at - oe_at == SETTLE, "R5 settle gap", w_at - oe_at, SETTLE);
    end else begin
      chk(!bus_oe, "R2/R3 no drive on write", bus_oe, 0);
    end
    // hold strobe a while: R8 one service per cycle
    repeat ($urandom_range(0, 5)) begin
      @(negedge clk);
      chk(wait_n, "R8 wait held", wait_n, 1);
    end
    chk(xfers - x0 <= 1, "R8 single transfer", xfers - x0, 1);
    astb_n = 1; dstb_n = 1;
    n = 0;
    while (wait_n && n < 50) begin
      @(negedge clk); n++;
      if (wait_n && !bus_oe) saw_rel = 1;
    end
    // R7 release order
    chk(!wait_n && !bus_oe && saw_rel, "R7 release order", {wait_n, bus_oe, saw_rel}, 3'b001);
    if (is_wr) begin
      if (is_addr) exp_ptr = wd; else exp_mem[exp_ptr] = wd;
    end
  endtask

  task automatic xfer(input bit is_addr, input bit is_wr, input logic [7:0] wd);
    start_op(is_addr, is_wr, wd);
    finish_op(is_addr, is_wr, wd);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin rmem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wait_n && !bus_oe && !reg_valid, "R1 reset state", {wait_n, bus_oe, reg_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!wait_n && !bus_oe && !reg_valid, "R1 idle after reset", {wait_n, bus_oe, reg_valid}, 0);
    // directed: pointer write/read at both ends
    xfer(1, 1, 8'h00); xfer(1, 0, 0);
    xfer(1, 1, 8'hFF); xfer(1, 0, 0);
    xfer(0, 1, 8'hA5); xfer(0, 0, 0);
    // R3 request fields on a write
    xfer(1, 1, 8'h3C);
    start_op(0, 1, 8'h5A);
    stall = 1;
    while (!reg_valid) @(negedge clk);
    chk(reg_write && reg_addr == 8'h3C && reg_wdata == 8'h5A, "R3 write request",
        {reg_write, reg_addr, reg_wdata}, {1'b1, 8'h3C, 8'h5A});
    // R4 stall: wait held low, request stable
    repeat (25) begin
      @(negedge clk);
      chk(!wait_n && reg_valid && reg_addr == 8'h3C && reg_wdata == 8'h5A, "R4 stall hold",
          {wait_n, reg_valid, reg_addr}, {1'b0, 1'b1, 8'h3C});
    end
    stall = 0;
    finish_op(0, 1, 8'h5A);
    xfer(0, 0, 0);
    // R4 stall on a read
    start_op(0, 0, 0);
    stall = 1;
    repeat (20) begin
      @(negedge clk);
      chk(!wait_n && !bus_oe, "R4 read stall", {wait_n, bus_oe}, 0);
    end
    stall = 0;
    finish_op(0, 0, 0);
    // random mix
    for (int k = 0; k < 300; k++) begin
      automatic bit a = $urandom_range(0, 2) == 0;
      automatic bit w = $urandom_range(0, 1) == 1;
      xfer(a, w, 8'($urandom));
    end
    repeat (5) @(negedge clk);
    chk(!wait_n && !bus_oe && !reg_valid, "R1 idle at end", {wait_n, bus_oe, reg_valid}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule